// File: doc/BRIEF.md
# Multi-mode video pixel input formatter

This block accepts a 16-bit parallel video bus, sampled on every rising edge of a 27 MHz clock, and turns it into one uniform internal pixel stream. The stream has three 10-bit components and a valid strobe. In luma/chroma formats the components are Y on `compA`, Cb on `compB` and Cr on `compC`. In the RGB format they are G, B and R on the same three outputs. A 3-bit mode field picks the operating mode. In standard-definition mode, a 2-bit width code and an RGB-select bit then choose one of four bus layouts: 8-bit or 10-bit interleaved 4:2:2, 16-bit 4:2:2 with luma and chroma on separate bytes, or 16-bit packed 4:4:4 RGB.

The interleaved formats send words in the order Cb, Y, Cr, Y. A pulse on `lineStart` marks the cycle that carries a Cb word and restarts that order. The 16-bit formats carry one pixel on every second clock, counted from `lineStart`. Each arriving chroma word updates its own chroma output. Each luma word (or RGB word) presents a pixel with `pixValid` high. Configuration inputs are taken over only on a `lineStart` cycle. Two flags report the accepted configuration. `extSyncReq` says that embedded timing codes cannot be used. `otherMode` says that the selected mode belongs to a different capture path.

Top module: `vidInFormatter`

## Requirements
- R1: While `rstN` is low, all outputs are 0. The accepted configuration resets to mode 000 with width code 00 and RGB-select 0.
- R2: In mode 000 with width code 00 and RGB-select 0, the word on bus bits [15:8] is left-justified to 10 bits (two zero LSBs appended). Phase 0 (the `lineStart` cycle) is Cb and loads `compB`. Phase 2 is Cr and loads `compC`. Phases 1 and 3 are Y: they load `compA` and raise `pixValid` one cycle later. The phase then wraps from 3 back to 0.
- R3: With width code 10, the same word order is used, but the word is bus bits [15:6] taken unchanged.
- R4: With width code 01, a pixel is sampled on even phases only (every second clock from `lineStart`). On such a sample, Y = bus[15:8] left-justified, and bus[7:0] left-justified is loaded into `compB` on phase 0 or into `compC` on phase 2.
- R5: RGB-select 1 overrides the width code. On even phases, G is bus[10:5], expanded to 10 bits as {g, g[5:2]}, and goes to `compA`. B is bus[15:11], expanded as {b, b}, and goes to `compB`. R is bus[4:0], expanded as {r, r}, and goes to `compC`.
- R6: `pixValid` is never high on two consecutive cycles unless `lineStart` was high on the second of the two sampling edges.
- R7: `extSyncReq` is high exactly when the accepted mode is 000 and either RGB-select is 1 or the width code is 01.
- R8: `otherMode` is high exactly when the accepted mode is 001, 010 or 111. In every mode other than 000, including the unused codes, `pixValid` stays low and all components hold.
- R9: Changes to the mode, width code or RGB-select take effect only on a `lineStart` cycle. That cycle is phase 0, and it restarts both the word order and the half-rate sampling.
- R10: Width code 11 in mode 000 behaves as the 8-bit format.
- R11: `compA` changes only together with a pixel, that is, on a cycle where `pixValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel bus clock (27 MHz) |
| rstN | input | 1 | Active-low synchronous reset |
| busIn | input | 16 | Parallel pixel bus |
| lineStart | input | 1 | Marks a line's first word; loads configuration and restarts phase |
| modeSel | input | 3 | Input-mode field (000 = standard definition) |
| widthSel | input | 2 | Bus width code: 00 8-bit, 10 10-bit, 01 16-bit |
| rgbSel | input | 1 | Selects 16-bit 4:4:4 RGB, overriding the width code |
| pixValid | output | 1 | A pixel is present on the components |
| compA | output | 10 | Y, or G in RGB format |
| compB | output | 10 | Cb, or B in RGB format |
| compC | output | 10 | Cr, or R in RGB format |
| extSyncReq | output | 1 | External sync required; embedded timing codes not usable |
| otherMode | output | 1 | Accepted mode is a recognised non-SD mode |

## Verification
The bound checker watches four properties on every cycle. `pixValid` never pulses back to back except across a `lineStart` restart. The flags move only after a `lineStart`. No pixel appears in a recognised non-SD mode. `compA` never changes without `pixValid`. The exact lane positions, the left-justification and bit replication, the Cb/Y/Cr/Y order, the override of the width code by RGB-select, and the 11 width code can only be shown by the bench scenarios. Those scenarios compare a behavioural model against all outputs on every clock.

// File: rtl/vifPkg.sv
package vifPkg;
  localparam int BUS_W   = 16;
  localparam int COMP_W  = 10;
  localparam int MODE_W  = 3;
  localparam int WCODE_W = 2;
  localparam int PH_W    = 2;

  localparam logic [MODE_W-1:0]  MODE_SD   = 3'b000;
  localparam logic [MODE_W-1:0]  MODE_SDR  = 3'b001;
  localparam logic [MODE_W-1:0]  MODE_DDR  = 3'b010;
  localparam logic [MODE_W-1:0]  MODE_ED54 = 3'b111;
  localparam logic [WCODE_W-1:0] WCODE_16  = 2'b01;
  localparam logic [WCODE_W-1:0] WCODE_10  = 2'b10;

  typedef enum logic [1:0] {FMT_8, FMT_10, FMT_16, FMT_RGB} busFmt_e;

  typedef struct packed {
    logic    lumaEn;
    logic    cbEn;
    logic    crEn;
    logic    rgbEn;
    busFmt_e fmt;
  } vifStrobe_t;
endpackage

// File: rtl/vifCtrl.sv
module vifCtrl
  import vifPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineStart,
  input  logic [MODE_W-1:0]   modeSel,
  input  logic [WCODE_W-1:0]  widthSel,
  input  logic                rgbSel,
  output vifStrobe_t          strobe,
  output logic                extSyncReq,
  output logic                otherMode
);
  logic [MODE_W-1:0]  modeQ, effMode;
  logic [WCODE_W-1:0] widthQ, effWidth;
  logic               rgbQ, effRgb;
  logic [PH_W-1:0]    phaseQ, effPhase;
  busFmt_e            fmt;
  logic               sdEff;

  // configuration and phase restart on the line-start cycle itself
  always_comb begin
    effMode  = lineStart ? modeSel  : modeQ;
    effWidth = lineStart ? widthSel : widthQ;
    effRgb   = lineStart ? rgbSel   : rgbQ;
    effPhase = lineStart ? '0       : phaseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_SD;
      widthQ <= '0;
      rgbQ   <= 1'b0;
      phaseQ <= '0;
    end else begin
      modeQ  <= effMode;
      widthQ <= effWidth;
      rgbQ   <= effRgb;
      phaseQ <= effPhase + 1'b1;
    end
  end

  always_comb begin
    if (effRgb)                  fmt = FMT_RGB;
    else if (effWidth == WCODE_16) fmt = FMT_16;
    else if (effWidth == WCODE_10) fmt = FMT_10;
    else                         fmt = FMT_8;
  end

  assign sdEff = (effMode == MODE_SD);

  always_comb begin
    strobe = '0;
    strobe.fmt = fmt;
    if (sdEff) begin
      unique case (fmt)
        FMT_RGB: strobe.rgbEn = ~effPhase[0];
        FMT_16: begin
          strobe.lumaEn = ~effPhase[0];
          strobe.cbEn   = (effPhase == 2'd0);
          strobe.crEn   = (effPhase == 2'd2);
        end
        default: begin
          strobe.lumaEn = effPhase[0];
          strobe.cbEn   = (effPhase == 2'd0);
          strobe.crEn   = (effPhase == 2'd2);
        end
      endcase
    end
  end

  assign extSyncReq = (modeQ == MODE_SD) && (rgbQ || widthQ == WCODE_16);
  assign otherMode  = (modeQ == MODE_SDR) || (modeQ == MODE_DDR) || (modeQ == MODE_ED54);
endmodule

// File: rtl/vifDatapath.sv
module vifDatapath
  import vifPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  busIn,
  input  vifStrobe_t        strobe,
  output logic              pixValid,
  output logic [COMP_W-1:0] compA,
  output logic [COMP_W-1:0] compB,
  output logic [COMP_W-1:0] compC
);
  localparam int PAD8 = COMP_W - 8;

  logic [COMP_W-1:0] lumaWord, chromaWord;
  logic [COMP_W-1:0] gExp, bExp, rExp;

  always_comb begin
    unique case (strobe.fmt)
      FMT_10: begin
        lumaWord   = busIn[15:6];
        chromaWord = busIn[15:6];
      end
      FMT_16: begin
        lumaWord   = {busIn[15:8], {PAD8{1'b0}}};
        chromaWord = {busIn[7:0],  {PAD8{1'b0}}};
      end
      default: begin
        lumaWord   = {busIn[15:8], {PAD8{1'b0}}};
        chromaWord = {busIn[15:8], {PAD8{1'b0}}};
      end
    endcase
  end

  // packed 5-6-5 fields widened by repeating their top bits
  assign gExp = {busIn[10:5],  busIn[10:7]};
  assign bExp = {busIn[15:11], busIn[15:11]};
  assign rExp = {busIn[4:0],   busIn[4:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      compA    <= '0;
      compB    <= '0;
      compC    <= '0;
    end else begin
      pixValid <= strobe.lumaEn | strobe.rgbEn;
      if (strobe.rgbEn) begin
        compA <= gExp;
        compB <= bExp;
        compC <= rExp;
      end else begin
        if (strobe.lumaEn) compA <= lumaWord;
        if (strobe.cbEn)   compB <= chromaWord;
        if (strobe.crEn)   compC <= chromaWord;
      end
    end
  end
endmodule

// File: rtl/vidInFormatter.sv
module vidInFormatter
  import vifPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [BUS_W-1:0]   busIn,
  input  logic               lineStart,
  input  logic [MODE_W-1:0]  modeSel,
  input  logic [WCODE_W-1:0] widthSel,
  input  logic               rgbSel,
  output logic               pixValid,
  output logic [COMP_W-1:0]  compA,
  output logic [COMP_W-1:0]  compB,
  output logic [COMP_W-1:0]  compC,
  output logic               extSyncReq,
  output logic               otherMode
);
  vifStrobe_t strobe;

  vifCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .modeSel(modeSel),
    .widthSel(widthSel), .rgbSel(rgbSel), .strobe(strobe),
    .extSyncReq(extSyncReq), .otherMode(otherMode)
  );

  vifDatapath u_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .strobe(strobe),
    .pixValid(pixValid), .compA(compA), .compB(compB), .compC(compC)
  );
endmodule

// File: rtl/vifFormatterChk.sv
module vifFormatterChk
  import vifPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lineStart,
  input logic              pixValid,
  input logic [COMP_W-1:0] compA,
  input logic              extSyncReq,
  input logic              otherMode
);
  assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !lineStart) |=> !pixValid);

  assert_flag_on_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(extSyncReq) |-> $past(lineStart));

  assert_other_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    otherMode |-> !pixValid);

  assert_other_on_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(otherMode) |-> $past(lineStart));

  assert_luma_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> $stable(compA));
endmodule

bind vidInFormatter vifFormatterChk u_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .pixValid(pixValid),
  .compA(compA), .extSyncReq(extSyncReq), .otherMode(otherMode)
);

// File: tb/vidInFormatter_tb.sv
module vidInFormatter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busIn = '0;
  logic        lineStart = 1'b0;
  logic [2:0]  modeSel = 3'b000;
  logic [1:0]  widthSel = 2'b00;
  logic        rgbSel = 1'b0;
  logic        pixValid, extSyncReq, otherMode;
  logic [9:0]  compA, compB, compC;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int         mMode = 0, mWidth = 0, mRgb = 0, mPh = 0;
  logic       eValid = 0, eExt = 0, eOther = 0;
  logic [9:0] eA = 0, eB = 0, eC = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidInFormatter u_dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .lineStart(lineStart),
    .modeSel(modeSel), .widthSel(widthSel), .rgbSel(rgbSel),
    .pixValid(pixValid), .compA(compA), .compB(compB), .compC(compC),
    .extSyncReq(extSyncReq), .otherMode(otherMode)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "pixValid", int'(pixValid), int'(eValid));
    chk(tag, "compA", int'(compA), int'(eA));
    chk(tag, "compB", int'(compB), int'(eB));
    chk(tag, "compC", int'(compC), int'(eC));
    chk(tag, "extSyncReq", int'(extSyncReq), int'(eExt));
    chk(tag, "otherMode", int'(otherMode), int'(eOther));
  endtask

  task automatic modelStep(input logic [15:0] b, input logic ls);
    logic [9:0] word;
    if (ls) begin
      mMode = int'(modeSel); mWidth = int'(widthSel); mRgb = int'(rgbSel); mPh = 0;
    end
    eValid = 0;
    if (mMode == 0) begin
      if (mRgb == 1) begin
        if (mPh % 2 == 0) begin
          eValid = 1;
          eA = {b[10:5], b[10:7]};
          eB = {b[15:11], b[15:11]};
          eC = {b[4:0], b[4:0]};
        end
      end else if (mWidth == 1) begin
        if (mPh % 2 == 0) begin
          eValid = 1;
          eA = {b[15:8], 2'b00};
          if (mPh == 0) eB = {b[7:0], 2'b00};
          else          eC = {b[7:0], 2'b00};
        end
      end else begin
        word = (mWidth == 2) ? b[15:6] : {b[15:8], 2'b00};
        if (mPh == 0)      eB = word;
        else if (mPh == 2) eC = word;
        else begin eA = word; eValid = 1; end
      end
    end
    eExt   = (mMode == 0) && (mRgb == 1 || mWidth == 1);
    eOther = (mMode == 1) || (mMode == 2) || (mMode == 7);
    mPh = (mPh + 1) % 4;
  endtask

  task automatic step(input logic [15:0] b, input logic ls, input string tag);
    @(negedge clk);
    busIn = b;
    lineStart = ls;
    @(posedge clk);
    modelStep(b, ls);
    #1;
    compareAll(tag);
  endtask

  task automatic runLine(input int n, input int seed, input string tag);
    for (int i = 0; i < n; i++)
      step(16'((i + 1) * 16'h3a7b + seed * 16'h1d35), (i == 0), tag);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compareAll("R1 reset");
    @(negedge clk);
    rstN = 1'b1;

    // R2: 8-bit interleaved, left-justified
    runLine(9, 1, "R2 8-bit");
    // R9: width change without line start is ignored
    widthSel = 2'b10;
    for (int i = 0; i < 4; i++) step(16'(16'hc3f1 + i * 16'h0457), 1'b0, "R9 pending");
    // R3: 10-bit after line start
    runLine(8, 2, "R3 10-bit");
    // R10: width code 11 acts as 8-bit
    widthSel = 2'b11;
    runLine(8, 3, "R10 code11");
    // R4, R7: 16-bit half rate; then a restart at an odd phase (R9, R6)
    widthSel = 2'b01;
    runLine(9, 4, "R4 R7 16-bit");
    runLine(3, 5, "R9 restart");
    // R5: RGB overrides width code
    widthSel = 2'b00; rgbSel = 1'b1;
    runLine(8, 6, "R5 R7 rgb");
    step(16'hffff, 1'b1, "R5 allones");
    step(16'h0000, 1'b0, "R5 allones");
    step(16'hf800, 1'b0, "R5 blue");
    // R8: recognised other modes and an unused code
    rgbSel = 1'b0;
    modeSel = 3'b001; runLine(5, 7, "R8 mode001");
    modeSel = 3'b010; runLine(4, 8, "R8 mode010");
    modeSel = 3'b111; runLine(4, 9, "R8 mode111");
    modeSel = 3'b011; runLine(4, 10, "R8 mode011");
    // R11: back to SD, luma only moves with valid
    modeSel = 3'b000;
    runLine(12, 11, "R11 hold");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule